// File: doc/BRIEF.md
# Binary-Field Scalar Point Multiplier

This block computes the scalar multiple Q = k·P of a point on a non-supersingular binary elliptic curve y² + xy = x³ + a·x² + b. It works in projective coordinates, so it never needs a field inversion. A caller presents the scalar, the affine base point (x0, y0) and the curve constants a and b in one input beat. Some time later the block returns the projective coordinates X, Y, Z in one output beat. The caller divides by Z itself if it needs affine values.

Field elements are N-bit vectors over a type II optimal normal basis of GF(2^N), where 2N+1 is prime. Sixteen N-bit working registers hold the accumulator, the base point, the curve constants and the temporaries. A controller scans the scalar from its highest set bit downward. For each lower bit it runs a micro-program of field operations for a point doubling, and it runs a second micro-program that adds the base point when the bit is 1.

Each micro-operation is a multiply, an add or a square. It goes to a field unit over a start/done handshake, and only one operation is outstanding at a time. Both edges of the block use valid/ready handshakes:
- An input beat transfers when `in_valid` and `in_ready` are both high at a rising clock edge.
- `in_ready` is high only while the block is idle.
- A result beat, once `out_valid` rises, stays valid and unchanged until `out_ready` takes it.

Top module: `ecc_kp_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A beat is taken only when `in_valid` and `in_ready` are both high. From the cycle after acceptance until the output beat has transferred, `in_ready` stays 0, and input data offered during that time has no effect on the result.
- R3: A scalar of zero produces a result beat with `out_err` = 1 and X = Y = Z = 0. This beat has `out_valid` high in the first cycle after acceptance, and no field operation runs.
- R4: A scalar of 1 produces X = x0, Y = y0 and Z = the field one (the all-ones vector), with `out_err` = 0, in the first cycle after acceptance.
- R5: The accumulator starts at (x0, y0, 1), which stands for the highest set bit. Each lower bit then causes one doubling. A scalar 2^m therefore gives m doublings with no addition.
- R6: Each lower bit equal to 1 adds the base point after that bit's doubling. Addition uses A = x0·Z + X, B = y0·Z + Y, C = A + B and D = A²(A + a·Z) + Z·B·C. Its results are X' = A·D, Y' = C·D + A²(B·X + A·Y) and Z' = A³·Z. Doubling uses A = X·Z and B = b·Z⁴ + X⁴. Its results are X' = A·B, Y' = X⁴·A + B(X² + Y·Z + A) and Z' = A³.
- R7: Field addition is bitwise XOR. Squaring rotates the vector one place toward the most significant bit: bit i moves to bit i+1, and bit N−1 moves to bit 0. The product of basis elements i and j is the sum of the basis elements whose exponents are ±(2^i + 2^j) and ±(2^i − 2^j) mod 2N+1, where an exponent of 0 contributes nothing.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_x`, `out_y`, `out_z` and `out_err` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request beat offered |
| in_ready | output | 1 | Block idle, can take a request |
| in_k | input | N | Scalar k |
| in_x0 | input | N | Base point x, normal basis |
| in_y0 | input | N | Base point y, normal basis |
| in_a | input | N | Curve constant a |
| in_b | input | N | Curve constant b |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | N | Projective X of k·P |
| out_y | output | N | Projective Y of k·P |
| out_z | output | N | Projective Z of k·P |
| out_err | output | 1 | Scalar was zero |

## Verification
The two functions that can fall in the same cycle are the output hand-off and the acceptance of the next request. The bench holds `in_valid` high with a second job for the whole of a first job, and keeps the result back under a stalled `out_ready` for several cycles. It then raises `out_ready` while the second request is still offered. The checks require that the stalled result stays unchanged and equals the reference for the first job, that `in_ready` returns exactly one cycle after the hand-off, and that the second job's result matches its own reference. Expected results come from a bench-side ring model of the field and a direct evaluation of the projective formulas.

// File: rtl/ecc_kp_pkg.sv
package ecc_kp_pkg;

  typedef enum logic [1:0] {
    FOP_ADD = 2'd0,
    FOP_SQR = 2'd1,
    FOP_MUL = 2'd2
  } fop_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_OUT   = 2'd3
  } ctl_state_e;

  typedef struct packed {
    fop_e       op;
    logic [3:0] dst;
    logic [3:0] sa;
    logic [3:0] sb;
  } uop_t;

  localparam int NUM_REGS  = 16;
  localparam int DBL_STEPS = 16;
  localparam int ADD_STEPS = 21;
  localparam int PC_W      = 5;

  // Register roles: accumulator, base point copy, constants
  localparam int RG_X  = 0;
  localparam int RG_Y  = 1;
  localparam int RG_Z  = 2;
  localparam int RG_PX = 3;
  localparam int RG_PY = 4;
  localparam int RG_A  = 5;
  localparam int RG_B  = 6;

  function automatic uop_t mk(input fop_e o, input int d, input int a, input int b);
    uop_t u;
    u.op  = o;
    u.dst = 4'(d);
    u.sa  = 4'(a);
    u.sb  = 4'(b);
    return u;
  endfunction

  // Micro-program: point doubling (add_ph=0) and base-point addition (add_ph=1)
  function automatic uop_t uop_fetch(input logic add_ph, input logic [PC_W-1:0] pc);
    uop_t u;
    u = mk(FOP_ADD, 15, 15, 15);
    if (!add_ph) begin
      case (pc)
        5'd0:  u = mk(FOP_MUL, 7,  RG_X, RG_Z);  // A = X*Z
        5'd1:  u = mk(FOP_SQR, 8,  RG_X, RG_X);  // X^2
        5'd2:  u = mk(FOP_SQR, 9,  8,    8);     // X^4
        5'd3:  u = mk(FOP_SQR, 10, RG_Z, RG_Z);  // Z^2
        5'd4:  u = mk(FOP_SQR, 10, 10,   10);    // Z^4
        5'd5:  u = mk(FOP_MUL, 10, RG_B, 10);    // b*Z^4
        5'd6:  u = mk(FOP_ADD, 10, 10,   9);     // B
        5'd7:  u = mk(FOP_MUL, 11, RG_Y, RG_Z);  // Y*Z
        5'd8:  u = mk(FOP_ADD, 11, 11,   8);     // + X^2
        5'd9:  u = mk(FOP_ADD, 11, 11,   7);     // + A
        5'd10: u = mk(FOP_MUL, 11, 10,   11);    // B*(...)
        5'd11: u = mk(FOP_MUL, 12, 9,    7);     // X^4*A
        5'd12: u = mk(FOP_ADD, RG_Y, 12, 11);    // Y'
        5'd13: u = mk(FOP_MUL, RG_X, 7,  10);    // X' = A*B
        5'd14: u = mk(FOP_SQR, 12, 7,    7);     // A^2
        5'd15: u = mk(FOP_MUL, RG_Z, 12, 7);     // Z' = A^3
        default: u = mk(FOP_ADD, 15, 15, 15);
      endcase
    end else begin
      case (pc)
        5'd0:  u = mk(FOP_MUL, 7,  RG_PX, RG_Z); // x0*Z
        5'd1:  u = mk(FOP_ADD, 7,  7,     RG_X); // A
        5'd2:  u = mk(FOP_MUL, 8,  RG_PY, RG_Z); // y0*Z
        5'd3:  u = mk(FOP_ADD, 8,  8,     RG_Y); // B
        5'd4:  u = mk(FOP_ADD, 9,  7,     8);    // C
        5'd5:  u = mk(FOP_SQR, 10, 7,     7);    // A^2
        5'd6:  u = mk(FOP_MUL, 11, RG_A,  RG_Z); // a*Z
        5'd7:  u = mk(FOP_ADD, 11, 11,    7);    // A + a*Z
        5'd8:  u = mk(FOP_MUL, 11, 10,    11);   // A^2(A + aZ)
        5'd9:  u = mk(FOP_MUL, 12, RG_Z,  8);    // Z*B
        5'd10: u = mk(FOP_MUL, 12, 12,    9);    // Z*B*C
        5'd11: u = mk(FOP_ADD, 11, 11,    12);   // D
        5'd12: u = mk(FOP_MUL, 12, 8,     RG_X); // B*X
        5'd13: u = mk(FOP_MUL, 13, 7,     RG_Y); // A*Y
        5'd14: u = mk(FOP_ADD, 12, 12,    13);   // B*X + A*Y
        5'd15: u = mk(FOP_MUL, 12, 10,    12);   // A^2(...)
        5'd16: u = mk(FOP_MUL, 13, 9,     11);   // C*D
        5'd17: u = mk(FOP_ADD, RG_Y, 13,  12);   // Y'
        5'd18: u = mk(FOP_MUL, RG_X, 7,   11);   // X' = A*D
        5'd19: u = mk(FOP_MUL, 13, 10,    7);    // A^3
        5'd20: u = mk(FOP_MUL, RG_Z, 13,  RG_Z); // Z' = A^3*Z
        default: u = mk(FOP_ADD, 15, 15, 15);
      endcase
    end
    return u;
  endfunction

endpackage

// File: rtl/ecc_kp_onb_row.sv
module ecc_kp_onb_row #(
  parameter int N = 18
) (
  input  logic [N-1:0]         b,
  input  logic [$clog2(N)-1:0] sel,
  output logic [N-1:0]         row
);
  localparam int P  = 2 * N + 1;

  function automatic int pow2m(input int e);
    int r;
    r = 1;
    for (int t = 0; t < e; t++) r = (r * 2) % P;
    return r;
  endfunction

  // Basis vector for exponent e (e and P-e name the same basis element)
  function automatic logic [N-1:0] basis_of(input int e);
    logic [N-1:0] v;
    int r;
    v = '0;
    r = 1;
    for (int k = 0; k < N; k++) begin
      if (e != 0 && (r == e || r == P - e)) v[k] = 1'b1;
      r = (r * 2) % P;
    end
    return v;
  endfunction

  function automatic logic [N-1:0] basis_prod(input int i, input int j);
    int ei, ej;
    ei = pow2m(i);
    ej = pow2m(j);
    return basis_of((ei + ej) % P) ^ basis_of((ei - ej + P) % P);
  endfunction

  logic [N-1:0] ptab [N][N];

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      localparam logic [N-1:0] PV = basis_prod(gi, gj);
      assign ptab[gi][gj] = PV;
    end
  end

  always_comb begin
    row = '0;
    for (int j = 0; j < N; j++) begin
      if (b[j]) row = row ^ ptab[sel][j];
    end
  end

endmodule

// File: rtl/ecc_kp_field_unit.sv
module ecc_kp_field_unit
  import ecc_kp_pkg::*;
#(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  fop_e         op,
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] res
);
  localparam int CW = $clog2(N);

  fop_e          op_q;
  logic [N-1:0]  a_q, b_q, acc, row, acc_nxt;
  logic [CW-1:0] cnt;

  ecc_kp_onb_row #(.N(N)) u_row (
    .b   (b_q),
    .sel (cnt),
    .row (row)
  );

  assign acc_nxt = acc ^ ({N{a_q[cnt]}} & row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      res  <= '0;
      op_q <= FOP_ADD;
      a_q  <= '0;
      b_q  <= '0;
      acc  <= '0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        op_q <= op;
        a_q  <= opa;
        b_q  <= opb;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        case (op_q)
          FOP_ADD: begin
            res  <= a_q ^ b_q;
            done <= 1'b1;
            busy <= 1'b0;
          end
          FOP_SQR: begin
            res  <= {a_q[N-2:0], a_q[N-1]};
            done <= 1'b1;
            busy <= 1'b0;
          end
          default: begin
            acc <= acc_nxt;
            if (cnt == CW'(N - 1)) begin
              res  <= acc_nxt;
              done <= 1'b1;
              busy <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/ecc_kp_regfile.sv
module ecc_kp_regfile
  import ecc_kp_pkg::*;
#(
  parameter int N    = 18,
  parameter int NREG = NUM_REGS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  output logic [N-1:0]            qa,
  output logic [N-1:0]            qb,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [N-1:0]            wd,
  input  logic                    ld,
  input  logic [N-1:0]            ld_x,
  input  logic [N-1:0]            ld_y,
  input  logic [N-1:0]            ld_a,
  input  logic [N-1:0]            ld_b,
  output logic [N-1:0]            q_x,
  output logic [N-1:0]            q_y,
  output logic [N-1:0]            q_z
);
  logic [N-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else if (ld) begin
      mem[RG_X]  <= ld_x;
      mem[RG_Y]  <= ld_y;
      mem[RG_Z]  <= '1;
      mem[RG_PX] <= ld_x;
      mem[RG_PY] <= ld_y;
      mem[RG_A]  <= ld_a;
      mem[RG_B]  <= ld_b;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign qa  = mem[ra];
  assign qb  = mem[rb];
  assign q_x = mem[RG_X];
  assign q_y = mem[RG_Y];
  assign q_z = mem[RG_Z];

endmodule

// File: rtl/ecc_kp_engine.sv
module ecc_kp_engine
  import ecc_kp_pkg::*;
#(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_k,
  input  logic [N-1:0] in_x0,
  input  logic [N-1:0] in_y0,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_x,
  output logic [N-1:0] out_y,
  output logic [N-1:0] out_z,
  output logic         out_err
);
  localparam int BW = $clog2(N);

  ctl_state_e      state;
  logic [N-1:0]    k_q;
  logic [BW-1:0]   bidx, msb;
  logic            add_ph, err_q, accept, last_step, rf_ld;
  logic [PC_W-1:0] upc;
  uop_t            uop;

  logic         fu_start, fu_busy, fu_done;
  logic [N-1:0] fu_res, rd_a, rd_b, r_x, r_y, r_z;

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_OUT);
  assign accept    = in_valid && in_ready;
  assign uop       = uop_fetch(add_ph, upc);
  assign fu_start  = (state == S_ISSUE);
  assign rf_ld     = accept && (in_k != '0);
  assign last_step = add_ph ? (upc == PC_W'(ADD_STEPS - 1))
                            : (upc == PC_W'(DBL_STEPS - 1));

  always_comb begin
    msb = '0;
    for (int i = 0; i < N; i++) begin
      if (in_k[i]) msb = BW'(i);
    end
  end

  ecc_kp_regfile #(.N(N), .NREG(NUM_REGS)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .ra    (uop.sa),
    .rb    (uop.sb),
    .qa    (rd_a),
    .qb    (rd_b),
    .we    ((state == S_WAIT) && fu_done),
    .wa    (uop.dst),
    .wd    (fu_res),
    .ld    (rf_ld),
    .ld_x  (in_x0),
    .ld_y  (in_y0),
    .ld_a  (in_a),
    .ld_b  (in_b),
    .q_x   (r_x),
    .q_y   (r_y),
    .q_z   (r_z)
  );

  ecc_kp_field_unit #(.N(N)) u_fu (
    .clk   (clk),
    .rst_n (rst_n),
    .start (fu_start),
    .op    (uop.op),
    .opa   (rd_a),
    .opb   (rd_b),
    .busy  (fu_busy),
    .done  (fu_done),
    .res   (fu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      k_q    <= '0;
      bidx   <= '0;
      add_ph <= 1'b0;
      upc    <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            k_q    <= in_k;
            add_ph <= 1'b0;
            upc    <= '0;
            if (in_k == '0) begin
              err_q <= 1'b1;
              state <= S_OUT;
            end else begin
              err_q <= 1'b0;
              if (msb == '0) begin
                state <= S_OUT;
              end else begin
                bidx  <= msb - 1'b1;
                state <= S_ISSUE;
              end
            end
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (fu_done) begin
            if (!last_step) begin
              upc   <= upc + 1'b1;
              state <= S_ISSUE;
            end else if (!add_ph && k_q[bidx]) begin
              add_ph <= 1'b1;
              upc    <= '0;
              state  <= S_ISSUE;
            end else if (bidx == '0) begin
              state <= S_OUT;
            end else begin
              bidx   <= bidx - 1'b1;
              add_ph <= 1'b0;
              upc    <= '0;
              state  <= S_ISSUE;
            end
          end
        end
        default: begin
          if (out_ready) state <= S_IDLE;
        end
      endcase
    end
  end

  assign out_x   = err_q ? '0 : r_x;
  assign out_y   = err_q ? '0 : r_y;
  assign out_z   = err_q ? '0 : r_z;
  assign out_err = err_q;

endmodule

// File: rtl/ecc_kp_engine_chk.sv
module ecc_kp_engine_chk #(
  parameter int N = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_x,
  input logic [N-1:0] out_y,
  input logic [N-1:0] out_z,
  input logic         out_err,
  input logic         fu_start,
  input logic         fu_busy,
  input logic         fu_done
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (in_ready && !out_valid));

  a_r2_closed_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_no_accept_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r3_error_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_x == '0 && out_y == '0 && out_z == '0));

  a_r6_one_op_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |-> !fu_busy);

  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    fu_start |=> !fu_done);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_z) && $stable(out_err)));

endmodule

bind ecc_kp_engine ecc_kp_engine_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_z     (out_z),
  .out_err   (out_err),
  .fu_start  (fu_start),
  .fu_busy   (fu_busy),
  .fu_done   (fu_done)
);

// File: tb/ecc_kp_engine_bench.sv
module ecc_kp_engine_bench;
  localparam int N  = 18;
  localparam int P  = 2 * N + 1;
  localparam int NV = 8;
  localparam logic [N-1:0] ONE = '1;

  // {k, x0, y0, a, b}
  localparam logic [5*N-1:0] VEC [NV] = '{
    {18'h00003, 18'h2b1c5, 18'h13a7e, 18'h00001, 18'h3c9d2},
    {18'h00005, 18'h0f00f, 18'h31234, 18'h2aaaa, 18'h01357},
    {18'h000b6, 18'h12345, 18'h0abcd, 18'h00000, 18'h3ffff},
    {18'h20000, 18'h3a5a5, 18'h05a5a, 18'h11111, 18'h22222},
    {18'h3ffff, 18'h00f1e, 18'h3e0c1, 18'h3ffff, 18'h00007},
    {18'h2a5c3, 18'h1d2c3, 18'h2b4a5, 18'h15555, 18'h1a2b3},
    {18'h1000f, 18'h27b61, 18'h0c3d2, 18'h00100, 18'h3c0f0},
    {18'h00040, 18'h0001f, 18'h3f800, 18'h2468a, 18'h13579}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [N-1:0] in_k = '0, in_x0 = '0, in_y0 = '0, in_a = '0, in_b = '0;
  logic         in_ready, out_valid, out_err;
  logic [N-1:0] out_x, out_y, out_z;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk = ~clk;

  ecc_kp_engine #(.N(N)) u_ecc_kp_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_k      (in_k),
    .in_x0     (in_x0),
    .in_y0     (in_y0),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_x     (out_x),
    .out_y     (out_y),
    .out_z     (out_z),
    .out_err   (out_err)
  );

  // ---------------- reference field model: ring F2[x]/(x^P - 1) ----------------
  function automatic int pw(input int k);
    int r;
    r = 1;
    for (int t = 0; t < k; t++) r = (r * 2) % P;
    return r;
  endfunction

  function automatic logic [N-1:0] fm(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [P-1:0] ra, rb, z;
    logic [N-1:0] c;
    ra = '0; rb = '0; z = '0;
    for (int k = 0; k < N; k++) begin
      ra[pw(k)] ^= a[k]; ra[P - pw(k)] ^= a[k];
      rb[pw(k)] ^= b[k]; rb[P - pw(k)] ^= b[k];
    end
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        if (ra[i] && rb[j]) z[(i + j) % P] ^= 1'b1;
    for (int k = 0; k < N; k++) c[k] = z[pw(k)];
    return c;
  endfunction

  function automatic logic [3*N-1:0] ref_kp(input logic [N-1:0] k, x0, y0, ca, cb);
    logic [N-1:0] X, Y, Z, A, B, C, D, A2, X2, X4, Z4, nX, nY, nZ;
    int top;
    X = x0; Y = y0; Z = ONE; top = 0;
    for (int i = 0; i < N; i++) if (k[i]) top = i;
    for (int i = top - 1; i >= 0; i--) begin
      A  = fm(X, Z);
      X2 = fm(X, X);
      X4 = fm(X2, X2);
      Z4 = fm(fm(Z, Z), fm(Z, Z));
      B  = fm(cb, Z4) ^ X4;
      nX = fm(A, B);
      nY = fm(X4, A) ^ fm(B, X2 ^ fm(Y, Z) ^ A);
      nZ = fm(fm(A, A), A);
      X = nX; Y = nY; Z = nZ;
      if (k[i]) begin
        A  = fm(x0, Z) ^ X;
        B  = fm(y0, Z) ^ Y;
        C  = A ^ B;
        A2 = fm(A, A);
        D  = fm(A2, A ^ fm(ca, Z)) ^ fm(fm(Z, B), C);
        nX = fm(A, D);
        nY = fm(C, D) ^ fm(A2, fm(B, X) ^ fm(A, Y));
        nZ = fm(fm(A2, A), Z);
        X = nX; Y = nY; Z = nZ;
      end
    end
    return {X, Y, Z};
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check_eq(input string tag, input logic [3*N:0] act, input logic [3*N:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_job(input logic [5*N-1:0] v, output logic [3*N:0] got, output int lat);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    {in_k, in_x0, in_y0, in_a, in_b} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid) begin
      @(negedge clk);
      lat++;
    end
    got = {out_err, out_x, out_y, out_z};
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic [3*N:0] got, held;
    logic [5*N-1:0] va, vb;
    int lat, bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_eq("R1 in_ready", {54'd0, in_ready}, {54'd0, 1'b1});
    check_eq("R1 out_valid", {54'd0, out_valid}, '0);

    // R3: zero scalar
    run_job({18'h0, 18'h12345, 18'h23456, 18'h00011, 18'h00022}, got, lat);
    check_eq("R3 zero scalar beat", got, {1'b1, 54'd0});
    check_eq("R3 zero scalar latency", 55'(lat), 55'd0);

    // R4: unit scalar
    run_job({18'h1, 18'h2b1c5, 18'h13a7e, 18'h00001, 18'h3c9d2}, got, lat);
    check_eq("R4 unit scalar result", got, {1'b0, 18'h2b1c5, 18'h13a7e, ONE});
    check_eq("R4 unit scalar latency", 55'(lat), 55'd0);

    // R7: one doubling exercises multiply, square and add of the field
    va = {18'h2, 18'h0a0a1, 18'h3c3c3, 18'h00005, 18'h2f0f1};
    run_job(va, got, lat);
    check_eq("R7 single doubling", got, {1'b0, ref_kp(va[89:72], va[71:54], va[53:36], va[35:18], va[17:0])});

    // R5: power-of-two scalars take doublings only
    va = {18'h00100, 18'h1b2c3, 18'h0d4e5, 18'h00f0f, 18'h30303};
    run_job(va, got, lat);
    check_eq("R5 doubling chain", got, {1'b0, ref_kp(va[89:72], va[71:54], va[53:36], va[35:18], va[17:0])});

    // R6: vector table
    for (int v = 0; v < NV; v++) begin
      run_job(VEC[v], got, lat);
      check_eq($sformatf("R6 vector %0d", v), got,
               {1'b0, ref_kp(VEC[v][89:72], VEC[v][71:54], VEC[v][53:36], VEC[v][35:18], VEC[v][17:0])});
    end

    // R2 / R8: request held during busy, stalled result, hand-off with new request pending
    va = {18'h00013, 18'h1a1b1, 18'h2c2d2, 18'h00003, 18'h10101};
    vb = {18'h00007, 18'h3e3d3, 18'h01020, 18'h0ffff, 18'h2a2a2};
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    {in_k, in_x0, in_y0, in_a, in_b} = va;
    in_valid = 1'b1;
    @(negedge clk);
    {in_k, in_x0, in_y0, in_a, in_b} = vb;
    bad = 0;
    for (int c = 0; c < 12; c++) begin
      if (in_ready) bad++;
      @(negedge clk);
    end
    check_eq("R2 in_ready low while busy", 55'(bad), 55'd0);
    while (!out_valid) @(negedge clk);
    held = {out_err, out_x, out_y, out_z};
    check_eq("R2 ignored request during busy", held,
             {1'b0, ref_kp(va[89:72], va[71:54], va[53:36], va[35:18], va[17:0])});
    bad = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (!out_valid || in_ready || {out_err, out_x, out_y, out_z} !== held) bad++;
    end
    check_eq("R8 result held under stall", 55'(bad), 55'd0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check_eq("R2 ready returns after hand-off", {53'd0, in_ready, out_valid}, {53'd0, 2'b10});
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R2 second request taken", {54'd0, in_ready}, '0);
    while (!out_valid) @(negedge clk);
    got = {out_err, out_x, out_y, out_z};
    check_eq("R6 second job result", got,
             {1'b0, ref_kp(vb[89:72], vb[71:54], vb[53:36], vb[35:18], vb[17:0])});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;

    // R2: no acceptance without in_valid
    repeat (3) @(negedge clk);
    check_eq("R2 idle without request", {53'd0, in_ready, out_valid}, {53'd0, 2'b10});

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule